// File: doc/BRIEF.md
# DRAM Address Bit Mapper

This block turns a host-interface word address into the rank, bank group, bank, row and column fields sent to an SDRAM. Each SDRAM address bit takes its value from one host address bit. The number of that host bit is a fixed per-bit base plus a 5-bit offset that software programs. With this scheme a single configuration can place the bank bits below the row bits (row-bank-column) or above them (bank-row-column). It can also spread bank bits anywhere in between.

The configuration sits in twelve write-only registers that are loaded through a simple write port. The column routing depends on the data-bus width. In half width every column bit takes the source that the column bit one position below would have had in full width. In quarter width the shift is two positions. An offset of all ones switches a bit off, which forces it to zero.

A combinational flag, derived from the stored configuration, reports whether the mapping is unusable. This happens when two live SDRAM bits share one host bit, when a source lies beyond the host address, or when the width code is illegal. Addresses enter through a valid/ready handshake and leave through a registered output one cycle later.

Top module: `dram_addr_mapper`

## Requirements
- R1: An address is accepted in a cycle where in_valid and in_ready are both high. In the following cycle out_valid is high and the output fields hold its mapping. In any cycle that follows a cycle with no acceptance, out_valid is low and the output fields keep their previous values.
- R2: There are twelve configuration registers of 20 bits, numbered 0 to 11. Field n lives in register n/4, at bits 5*(n%4)+4 down to 5*(n%4). The field numbers are: 0 rank; 1 and 2 bank group bits 0 and 1; 3 to 5 bank bits 0 to 2; 6 to 12 column bits 3 to 9; 13 to 28 row bits 0 to 15. Register 11 bits [1:0] hold the width mode: 0 full, 1 half, 2 quarter. A write to index 12 to 15 changes nothing.
- R3: A programmable bit is driven by host bit (base + field). The bases are: column bit k → k; bank group bit i → 3+i; bank bit i → 3+i; rank → 6; row bit i → 6+i. For example, column bit 7 with field 2 is driven by host bit 9.
- R4: In full width mode, column bits 0, 1 and 2 equal host bits 0, 1 and 2 and cannot be programmed.
- R5: In half width mode, column bit k (k≥1) takes the source that column bit k-1 has in full mode, and column bit 0 is zero.
- R6: In quarter width mode, column bit k (k≥2) takes the source that column bit k-2 has in full mode, and column bits 0 and 1 are zero.
- R7: A field value of 31 disables its bit. The output bit is then 0 and the bit is left out of the conflict check.
- R8: map_conflict is high when two enabled, in-use SDRAM bits (including the fixed low column bits) resolve to the same host bit. It reflects the stored configuration from the cycle after a write.
- R9: A source index of 32 or more sets map_conflict, and that output bit reads 0. Width code 3 sets map_conflict and routes columns as in full mode.
- R10: in_ready is low in every cycle in which cfg_we is high, so no address is accepted together with a write. An address held through the write is accepted in the next cycle under the new configuration.
- R11: After reset all fields are 31, the mode is full, out_valid is 0, all output fields are 0, map_conflict is 0 and in_ready is 1.
- R12: In half and quarter width modes, the topmost column fields that the shift leaves with no column bit to drive are left out of the conflict check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Register number for the write |
| cfg_wdata | input | 20 | Four 5-bit fields, or the width code in register 11 |
| in_valid | input | 1 | Host word address is present |
| in_ready | output | 1 | Block can take an address this cycle |
| in_addr | input | 32 | Host word address |
| out_valid | output | 1 | Mapped fields are valid |
| out_rank | output | 1 | Rank select |
| out_bg | output | 2 | Bank group |
| out_bank | output | 3 | Bank |
| out_row | output | 16 | Row address |
| out_col | output | 10 | Column address |
| map_conflict | output | 1 | Programmed mapping is not usable |

## Verification
Walking-one addresses feed a single host bit at a time. Each result therefore shows which SDRAM bit, if any, a given host bit reaches. This separates the row-bank-column and bank-row-column layouts and the three column shifts bit by bit. Dense mixed words (all ones and irregular constants) expose any crosstalk or inversion that single bits would hide. A word of all ones sent with every field disabled shows that disabled bits stay at zero while the fixed column bits still pass through. The conflict flag is driven through a shared source, an out-of-range offset, the illegal width code and a field that a width shift leaves unused, and each case is followed by a recovery. A write that coincides with a pending address shows that the address waits and is mapped with the new setting.

// File: rtl/dram_addr_mapper.sv
module dram_addr_mapper #(
  parameter int HIF_W  = 32,
  parameter int RANK_W = 1,
  parameter int BG_W   = 2,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 16,
  parameter int COL_W  = 10,
  parameter int FLD_W  = 5,
  parameter int IDX_W  = 4,
  parameter int NREG   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [4*FLD_W-1:0] cfg_wdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [HIF_W-1:0]  in_addr,
  output logic              out_valid,
  output logic [RANK_W-1:0] out_rank,
  output logic [BG_W-1:0]   out_bg,
  output logic [BANK_W-1:0] out_bank,
  output logic [ROW_W-1:0]  out_row,
  output logic [COL_W-1:0]  out_col,
  output logic              map_conflict
);
  localparam int FIX_COL  = 3;
  localparam int MODE_REG = NREG - 1;
  localparam int F_BG     = RANK_W;
  localparam int F_BANK   = F_BG + BG_W;
  localparam int F_COL    = F_BANK + BANK_W;
  localparam int F_ROW    = F_COL + COL_W - FIX_COL;
  localparam int NF       = F_ROW + ROW_W;
  localparam int O_BANK   = COL_W;
  localparam int O_BG     = O_BANK + BANK_W;
  localparam int O_ROW    = O_BG + BG_W;
  localparam int O_RANK   = O_ROW + ROW_W;
  localparam int NB       = O_RANK + RANK_W;
  localparam int AW       = $clog2(HIF_W);
  localparam int SW       = $clog2(6 + ROW_W + COL_W + (1 << FLD_W)) + 1;
  localparam logic [FLD_W-1:0] DIS = '1;

  function automatic int base_of(int f);
    if (f < F_BG)   return 6 + f;
    if (f < F_BANK) return 3 + f - F_BG;
    if (f < F_COL)  return 3 + f - F_BANK;
    if (f < F_ROW)  return FIX_COL + f - F_COL;
    return 6 + f - F_ROW;
  endfunction

  logic [FLD_W-1:0] fld [NF];
  logic [1:0]       mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int f = 0; f < NF; f++) fld[f] <= DIS;
      mode <= 2'd0;
    end else if (cfg_we) begin
      for (int f = 0; f < NF; f++)
        if (int'(cfg_idx) == f / 4) fld[f] <= cfg_wdata[FLD_W*(f%4) +: FLD_W];
      if (int'(cfg_idx) == MODE_REG) mode <= cfg_wdata[1:0];
    end
  end

  logic [SW-1:0] fsrc [NF];
  logic          fen  [NF];
  for (genvar f = 0; f < NF; f++) begin : g_fld
    assign fsrc[f] = SW'(base_of(f)) + SW'(fld[f]);
    assign fen[f]  = fld[f] != DIS;
  end

  logic [1:0]  shift;
  logic [SW:0] cfull [COL_W];
  logic [SW:0] omap  [NB];
  assign shift = (mode == 2'd1) ? 2'd1 : (mode == 2'd2) ? 2'd2 : 2'd0;

  for (genvar k = 0; k < COL_W; k++) begin : g_col
    logic [SW:0] c1, c2;
    if (k < FIX_COL) begin : g_fix
      assign cfull[k] = {1'b1, SW'(k)};
    end else begin : g_prog
      assign cfull[k] = {fen[F_COL+k-FIX_COL], fsrc[F_COL+k-FIX_COL]};
    end
    if (k >= 1) begin : g_s1
      assign c1 = cfull[k-1];
    end else begin : g_z1
      assign c1 = '0;
    end
    if (k >= 2) begin : g_s2
      assign c2 = cfull[k-2];
    end else begin : g_z2
      assign c2 = '0;
    end
    assign omap[k] = (shift == 2'd1) ? c1 : (shift == 2'd2) ? c2 : cfull[k];
  end

  for (genvar i = 0; i < BANK_W; i++) begin : g_bank
    assign omap[O_BANK+i] = {fen[F_BANK+i], fsrc[F_BANK+i]};
  end
  for (genvar i = 0; i < BG_W; i++) begin : g_bg
    assign omap[O_BG+i] = {fen[F_BG+i], fsrc[F_BG+i]};
  end
  for (genvar i = 0; i < ROW_W; i++) begin : g_row
    assign omap[O_ROW+i] = {fen[F_ROW+i], fsrc[F_ROW+i]};
  end
  for (genvar i = 0; i < RANK_W; i++) begin : g_rank
    assign omap[O_RANK+i] = {fen[i], fsrc[i]};
  end

  logic [NB-1:0] mbit;
  for (genvar b = 0; b < NB; b++) begin : g_bit
    logic live;
    assign live    = omap[b][SW] && (omap[b][SW-1:0] < SW'(HIF_W));
    assign mbit[b] = live && in_addr[omap[b][AW-1:0]];
  end

  logic [HIF_W-1:0] used;
  always_comb begin
    used = '0;
    map_conflict = (mode == 2'd3);
    for (int b = 0; b < NB; b++) begin
      if (omap[b][SW]) begin
        if (omap[b][SW-1:0] >= SW'(HIF_W)) map_conflict = 1'b1;
        else begin
          if (used[omap[b][AW-1:0]]) map_conflict = 1'b1;
          used[omap[b][AW-1:0]] = 1'b1;
        end
      end
    end
  end

  logic acc;
  assign in_ready = !cfg_we;
  assign acc      = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_col   <= '0;
      out_bank  <= '0;
      out_bg    <= '0;
      out_row   <= '0;
      out_rank  <= '0;
    end else begin
      out_valid <= acc;
      if (acc) begin
        out_col  <= mbit[COL_W-1:0];
        out_bank <= mbit[O_BANK +: BANK_W];
        out_bg   <= mbit[O_BG +: BG_W];
        out_row  <= mbit[O_ROW +: ROW_W];
        out_rank <= mbit[O_RANK +: RANK_W];
      end
    end
  end

  p_accept_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !out_valid && $stable(out_row) && $stable(out_col) && $stable(out_bank));
  p_fixed_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode == 2'd0) |=> out_col[FIX_COL-1:0] == $past(in_addr[FIX_COL-1:0]));
  p_half_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode == 2'd1) |=> out_col[0] == 1'b0);
  p_quarter_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && mode == 2'd2) |=> out_col[1:0] == 2'b00);
  p_rank_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && fld[0] == DIS) |=> out_rank[0] == 1'b0);
  p_bad_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> map_conflict);
  p_no_take_on_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> !out_valid);
endmodule

// File: tb/dram_addr_mapper_tb.sv
module dram_addr_mapper_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, cfg_we = 1'b0, in_valid = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [19:0] cfg_wdata = '0;
  logic [31:0] in_addr = '0;
  logic        in_ready, out_valid, map_conflict;
  logic [0:0]  out_rank;
  logic [1:0]  out_bg;
  logic [2:0]  out_bank;
  logic [15:0] out_row;
  logic [9:0]  out_col;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_addr_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_rank(out_rank), .out_bg(out_bg), .out_bank(out_bank),
    .out_row(out_row), .out_col(out_col), .map_conflict(map_conflict));

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [4:0]  fld [29];
  int          mode_m = 0;
  logic [31:0] q_exp [$];
  string       q_tag [$];
  logic [31:0] mon_exp, mon_got;
  string       mon_tag;

  function automatic int base_f(int f);
    if (f < 1)  return 6 + f;
    if (f < 3)  return 3 + f - 1;
    if (f < 6)  return 3 + f - 3;
    if (f < 13) return 3 + f - 6;
    return 6 + f - 13;
  endfunction

  function automatic logic pick(int f, logic [31:0] a);
    int s;
    if (fld[f] == 5'd31) return 1'b0;
    s = base_f(f) + int'(fld[f]);
    if (s >= 32) return 1'b0;
    return a[s];
  endfunction

  function automatic int shift_m();
    return (mode_m == 1) ? 1 : (mode_m == 2) ? 2 : 0;
  endfunction

  function automatic logic [31:0] model(logic [31:0] a);
    logic [9:0] c; logic [2:0] bk; logic [1:0] g; logic [15:0] r; logic rk; int j;
    for (int k = 0; k < 10; k++) begin
      j = k - shift_m();
      if (j < 0) c[k] = 1'b0;
      else if (j < 3) c[k] = a[j];
      else c[k] = pick(3 + j, a);
    end
    for (int i = 0; i < 3; i++) bk[i] = pick(3 + i, a);
    for (int i = 0; i < 2; i++) g[i] = pick(1 + i, a);
    for (int i = 0; i < 16; i++) r[i] = pick(13 + i, a);
    rk = pick(0, a);
    return {rk, g, bk, r, c};
  endfunction

  function automatic bit conf_model();
    bit hit [64]; bit bad; int s, j;
    bad = (mode_m == 3);
    for (int i = 0; i < 64; i++) hit[i] = 1'b0;
    for (int k = 0; k < 10; k++) begin
      j = k - shift_m(); s = -1;
      if (j >= 0 && j < 3) s = j;
      else if (j >= 3 && fld[3+j] != 5'd31) s = base_f(3 + j) + int'(fld[3+j]);
      if (s >= 0) begin
        if (s >= 32 || hit[s]) bad = 1'b1;
        hit[s] = 1'b1;
      end
    end
    for (int f = 0; f < 29; f++)
      if ((f < 6 || f >= 13) && fld[f] != 5'd31) begin
        s = base_f(f) + int'(fld[f]);
        if (s >= 32 || hit[s]) bad = 1'b1;
        hit[s] = 1'b1;
      end
    return bad;
  endfunction

  task automatic check(bit ok, string tag, string what, logic [63:0] got, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  function automatic logic [19:0] compose(int r);
    logic [19:0] d = '0;
    for (int s = 0; s < 4; s++) if (4*r + s < 29) d[5*s +: 5] = fld[4*r + s];
    if (r == 11) d[1:0] = 2'(mode_m);
    return d;
  endfunction

  task automatic wr_reg(int r);
    @(negedge clk); cfg_we = 1'b1; cfg_idx = 4'(r); cfg_wdata = compose(r);
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic write_all();
    for (int r = 0; r < 12; r++) wr_reg(r);
  endtask

  task automatic send(logic [31:0] a, string tag);
    @(negedge clk); in_valid = 1'b1; in_addr = a;
    q_exp.push_back(model(a)); q_tag.push_back(tag);
  endtask

  task automatic drain();
    @(negedge clk); in_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_conf(string tag);
    bit e;
    e = conf_model();
    check(map_conflict == e, tag, "conflict flag", 64'(map_conflict), 64'(e));
  endtask

  task automatic walk(string tag);
    for (int i = 0; i < 32; i++) send(32'h1 << i, tag);
    send(32'hFFFF_FFFF, tag); send(32'hDEAD_BEEF, tag);
    send(32'h1234_5678, tag); send(32'hA5A5_5A5A, tag);
    drain();
  endtask

  task automatic load_rbc();
    fld[0] = 5'd25;
    for (int f = 1; f < 3; f++)   fld[f] = 5'd10;
    for (int f = 3; f < 6; f++)   fld[f] = 5'd7;
    for (int f = 6; f < 13; f++)  fld[f] = 5'd0;
    for (int f = 13; f < 29; f++) fld[f] = 5'd9;
    mode_m = 0;
    write_all();
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      mon_got = {out_rank, out_bg, out_bank, out_row, out_col};
      if (q_exp.size() == 0) check(1'b0, "R1", "unexpected output", 64'(mon_got), 64'(0));
      else begin
        mon_exp = q_exp.pop_front();
        mon_tag = q_tag.pop_front();
        check(mon_got == mon_exp, mon_tag, "mapped fields", 64'(mon_got), 64'(mon_exp));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    n_cmp++; n_bad++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int f = 0; f < 29; f++) fld[f] = 5'd31;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R11", "out_valid after reset", 64'(out_valid), 64'(0));
    check(map_conflict == 1'b0, "R11", "conflict after reset", 64'(map_conflict), 64'(0));
    check(in_ready == 1'b1, "R11", "in_ready after reset", 64'(in_ready), 64'(1));
    check({out_rank, out_bg, out_bank, out_row, out_col} == 32'h0, "R11", "fields after reset",
          64'({out_rank, out_bg, out_bank, out_row, out_col}), 64'(0));

    // R7 and R4: everything disabled, fixed column bits still pass
    send(32'hFFFF_FFFF, "R7"); send(32'h0000_0005, "R4"); drain();

    // R2, R3, R8: row-bank-column layout
    load_rbc(); chk_conf("R8");
    walk("R3");

    // bank-row-column layout
    for (int f = 13; f < 29; f++) fld[f] = 5'd4;
    for (int f = 3; f < 6; f++)   fld[f] = 5'd23;
    for (int f = 1; f < 3; f++)   fld[f] = 5'd26;
    write_all(); chk_conf("R2");
    walk("R2");

    // R3 worked example: column bit 7 field 2 -> host bit 9
    load_rbc();
    fld[10] = 5'd2; fld[12] = 5'd31; write_all(); chk_conf("R3");
    send(32'h1 << 9, "R3"); send(32'h1 << 7, "R3"); drain();

    // R5 half width, R12 leftover field ignored
    load_rbc(); mode_m = 1; wr_reg(11); chk_conf("R12");
    walk("R5");
    fld[12] = 5'd7; wr_reg(3);
    check(map_conflict == 1'b0, "R12", "unused field in half mode", 64'(map_conflict), 64'(0));
    mode_m = 0; wr_reg(11);
    check(map_conflict == 1'b1, "R8", "same field in full mode", 64'(map_conflict), 64'(1));
    fld[12] = 5'd0; wr_reg(3);

    // R6 quarter width
    mode_m = 2; wr_reg(11); chk_conf("R6");
    walk("R6");
    mode_m = 0; wr_reg(11);

    // R8 shared source, R7 disable clears it
    fld[1] = 5'd7; wr_reg(0);
    check(map_conflict == 1'b1, "R8", "shared source", 64'(map_conflict), 64'(1));
    fld[1] = 5'd31; wr_reg(0);
    check(map_conflict == 1'b0, "R7", "disabled bit not checked", 64'(map_conflict), 64'(0));
    send(32'hFFFF_FFFF, "R7"); drain();
    fld[1] = 5'd10; wr_reg(0);

    // R9 out of range source and illegal width code
    fld[28] = 5'd30; wr_reg(7);
    check(map_conflict == 1'b1, "R9", "source out of range", 64'(map_conflict), 64'(1));
    send(32'hFFFF_FFFF, "R9"); drain();
    fld[28] = 5'd9; wr_reg(7);
    check(map_conflict == 1'b0, "R9", "range restored", 64'(map_conflict), 64'(0));
    mode_m = 3; wr_reg(11);
    check(map_conflict == 1'b1, "R9", "width code 3", 64'(map_conflict), 64'(1));
    send(32'h0000_03FF, "R9"); drain();
    mode_m = 0; wr_reg(11);
    // write to an unused index leaves mapping unchanged
    @(negedge clk); cfg_we = 1'b1; cfg_idx = 4'd13; cfg_wdata = 20'hFFFFF;
    @(negedge clk); cfg_we = 1'b0;
    chk_conf("R2");
    send(32'hFFFF_FFFF, "R2"); drain();

    // R10 write held against a pending address
    fld[2] = 5'd31;
    @(negedge clk); cfg_we = 1'b1; cfg_idx = 4'd0; cfg_wdata = compose(0);
    in_valid = 1'b1; in_addr = 32'h0000_4000;
    #1 check(in_ready == 1'b0, "R10", "ready during write", 64'(in_ready), 64'(0));
    @(negedge clk); cfg_we = 1'b0;
    q_exp.push_back(model(32'h0000_4000)); q_tag.push_back("R10");
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);

    check(q_exp.size() == 0, "R1", "outputs missing", 64'(q_exp.size()), 64'(0));
    finish_run();
  end
endmodule